// File: doc/BRIEF.md
# MMU Fault Exception Entry Unit

This block performs the processor's exception entry when a memory management fault is reported. A single-cycle strobe carries either a fault class (one of eight translation faults) or a raw 12-bit event code from another source. On the clock edge that samples the strobe, the block saves the current status word, program counter and stack register into shadow copies. It forces the block, privilege and bank bits of the status word, records the event code, latches the faulting address for translation faults, and computes the handler address from the vector base.

The request side is a plain strobe with no back-pressure. The unit accepts one entry on every cycle in which the strobe is high, so back-to-back strobes are all taken and each overwrites the previous result. On a cycle without a strobe every output register keeps its value. The surrounding core supplies the current status, program counter, vector base and stack register values and takes the updated values from the outputs.

Top module: `mmu_fault_entry`

## Requirements
- R1: After reset, status_o is 32'h7000_0000, pc_o is 32'hA000_0000, and saved_status_o, saved_pc_o, saved_r15_o, event_o and fault_addr_o are all zero.
- R2: In a cycle where fault_valid_i is low, every output keeps its value at the next clock edge.
- R3: On an entry, one clock after the sampling edge, status_o equals status_i OR 32'h7000_0000 (bit 28 block, bit 29 bank, bit 30 privilege), saved_status_o equals status_i, saved_pc_o equals pc_i, and saved_r15_o equals r15_i.
- R4: event_o receives the 12-bit entry code masked to its low 11 bits (code & 11'h7FF).
- R5: With use_raw_i low, fault_class_i selects the code: 0 instruction miss → 0x040, 1 data read miss → 0x040, 2 data write miss → 0x060, 3 multiple hit → 0x140, 4 instruction protection → 0x0A0, 5 read protection → 0x0A0, 6 write protection → 0x0C0, 7 first write to clean page → 0x080. With use_raw_i high, raw_code_i is the code.
- R6: A full 12-bit code of 0x040, 0x060 or 0x080 sets pc_o to vbr_i + 0x400 (modulo 2^32).
- R7: A full 12-bit code of 0x140 sets pc_o to 32'hA000_0000, whatever vbr_i is.
- R8: Every other full 12-bit code, including codes such as 0x840 whose low 11 bits match a miss code, sets pc_o to vbr_i + 0x100 (modulo 2^32).
- R9: fault_addr_o takes fault_addr_i on every translation-fault entry (use_raw_i low) and keeps its value on raw-code entries.
- R10: There is no back-pressure. Strobes on consecutive cycles are each applied, and each one uses the inputs of its own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid_i | input | 1 | Entry strobe, one entry per high cycle |
| use_raw_i | input | 1 | Take raw_code_i instead of a fault class |
| fault_class_i | input | 3 | Translation fault class (see R5) |
| raw_code_i | input | 12 | Event code from a non-translation source |
| fault_addr_i | input | 32 | Faulting virtual address |
| status_i | input | 32 | Current status word |
| pc_i | input | 32 | Program counter of the faulting instruction |
| vbr_i | input | 32 | Vector base |
| r15_i | input | 32 | Current stack register |
| status_o | output | 32 | Updated status word |
| saved_status_o | output | 32 | Saved status word |
| saved_pc_o | output | 32 | Saved program counter |
| saved_r15_o | output | 32 | Saved stack register |
| event_o | output | 11 | Recorded event code |
| fault_addr_o | output | 32 | Latched fault address |
| pc_o | output | 32 | Handler address |

## Verification
The bench uses the default parameters: 32-bit data, a 12-bit code and 11-bit event field, and status bits 28 to 30. With these values it can sweep all eight fault classes against several vector bases, one of which makes the miss offset wrap past 2^32. It also runs every one of the 4096 raw codes back to back. This covers the miss codes that alias after masking and the 0x140 fixed-target case.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  localparam int CODE_W = 12;

  typedef enum logic [2:0] {
    FC_IMISS = 3'd0,
    FC_RMISS = 3'd1,
    FC_WMISS = 3'd2,
    FC_MULTI = 3'd3,
    FC_IPROT = 3'd4,
    FC_RPROT = 3'd5,
    FC_WPROT = 3'd6,
    FC_DIRTY = 3'd7
  } fault_class_e;

  localparam logic [CODE_W-1:0] EV_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] EV_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] EV_DIRTY   = 12'h080;
  localparam logic [CODE_W-1:0] EV_PROT_RD = 12'h0A0;
  localparam logic [CODE_W-1:0] EV_PROT_WR = 12'h0C0;
  localparam logic [CODE_W-1:0] EV_MULTI   = 12'h140;
endpackage

// File: rtl/mfe_code_map.sv
module mfe_code_map
  import mfe_pkg::*;
(
  input  fault_class_e            cls_i,
  input  logic                    use_raw_i,
  input  logic [CODE_W-1:0]       raw_i,
  output logic [CODE_W-1:0]       code_o
);
  logic [CODE_W-1:0] mapped;

  // R5: class to event code
  always_comb begin
    unique case (cls_i)
      FC_IMISS, FC_RMISS: mapped = EV_MISS_RD;
      FC_WMISS:           mapped = EV_MISS_WR;
      FC_MULTI:           mapped = EV_MULTI;
      FC_IPROT, FC_RPROT: mapped = EV_PROT_RD;
      FC_WPROT:           mapped = EV_PROT_WR;
      FC_DIRTY:           mapped = EV_DIRTY;
      default:            mapped = EV_MISS_RD;
    endcase
  end

  assign code_o = use_raw_i ? raw_i : mapped;
endmodule

// File: rtl/mfe_vector_sel.sv
module mfe_vector_sel
  import mfe_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] MISS_OFS  = 32'h0000_0400,
  parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0100,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000
)(
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   vbr_i,
  output logic [XLEN-1:0]   target_o
);
  logic is_miss, is_multi;

  // R6/R7/R8: decision on the full, unmasked code
  assign is_miss  = (code_i == EV_MISS_RD) || (code_i == EV_MISS_WR) ||
                    (code_i == EV_DIRTY);
  assign is_multi = (code_i == EV_MULTI);

  always_comb begin
    if (is_multi)     target_o = RESET_VEC;
    else if (is_miss) target_o = vbr_i + MISS_OFS;
    else              target_o = vbr_i + GEN_OFS;
  end
endmodule

// File: rtl/mfe_state_bank.sv
module mfe_state_bank #(
  parameter int XLEN      = 32,
  parameter int EVT_W     = 11,
  parameter int BLOCK_BIT = 28,
  parameter int BANK_BIT  = 29,
  parameter int PRIV_BIT  = 30,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            mmu_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] r15_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [EVT_W-1:0] event_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] saved_status_o,
  output logic [XLEN-1:0] saved_pc_o,
  output logic [XLEN-1:0] saved_r15_o,
  output logic [EVT_W-1:0] event_o,
  output logic [XLEN-1:0] fault_addr_o,
  output logic [XLEN-1:0] pc_o
);
  localparam logic [XLEN-1:0] FORCE_MASK =
    (XLEN'(1) << BLOCK_BIT) | (XLEN'(1) << BANK_BIT) | (XLEN'(1) << PRIV_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o       <= FORCE_MASK;
      saved_status_o <= '0;
      saved_pc_o     <= '0;
      saved_r15_o    <= '0;
      event_o        <= '0;
      fault_addr_o   <= '0;
      pc_o           <= RESET_VEC;
    end else if (take_i) begin
      status_o       <= status_i | FORCE_MASK;
      saved_status_o <= status_i;
      saved_pc_o     <= pc_i;
      saved_r15_o    <= r15_i;
      event_o        <= event_i;
      pc_o           <= target_i;
      if (mmu_i) fault_addr_o <= addr_i;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> ($stable(status_o) && $stable(saved_status_o) && $stable(saved_pc_o)
                 && $stable(saved_r15_o) && $stable(event_o) && $stable(pc_o)
                 && $stable(fault_addr_o)));

  a_r3_status: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (status_o[BLOCK_BIT] && status_o[BANK_BIT] && status_o[PRIV_BIT]));

  a_r3_saved: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (saved_status_o == $past(status_i) && saved_r15_o == $past(r15_i)
                && saved_pc_o == $past(pc_i)));

  a_r9_mmu_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && mmu_i) |=> fault_addr_o == $past(addr_i));

  a_r9_raw_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !mmu_i) |=> $stable(fault_addr_o));
endmodule

// File: rtl/mmu_fault_entry.sv
module mmu_fault_entry
  import mfe_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int EVT_W     = 11,
  parameter int BLOCK_BIT = 28,
  parameter int BANK_BIT  = 29,
  parameter int PRIV_BIT  = 30,
  parameter logic [XLEN-1:0] MISS_OFS  = 32'h0000_0400,
  parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0100,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid_i,
  input  logic              use_raw_i,
  input  logic [2:0]        fault_class_i,
  input  logic [CODE_W-1:0] raw_code_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [XLEN-1:0]   r15_i,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   saved_status_o,
  output logic [XLEN-1:0]   saved_pc_o,
  output logic [XLEN-1:0]   saved_r15_o,
  output logic [EVT_W-1:0]  event_o,
  output logic [XLEN-1:0]   fault_addr_o,
  output logic [XLEN-1:0]   pc_o
);
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   target;
  logic [EVT_W-1:0]  evt;

  mfe_code_map u_map (
    .cls_i     (fault_class_e'(fault_class_i)),
    .use_raw_i (use_raw_i),
    .raw_i     (raw_code_i),
    .code_o    (code)
  );

  mfe_vector_sel #(
    .XLEN(XLEN), .MISS_OFS(MISS_OFS), .GEN_OFS(GEN_OFS), .RESET_VEC(RESET_VEC)
  ) u_vec (
    .code_i   (code),
    .vbr_i    (vbr_i),
    .target_o (target)
  );

  // R4: event field keeps the low bits only
  assign evt = code[EVT_W-1:0];

  mfe_state_bank #(
    .XLEN(XLEN), .EVT_W(EVT_W), .BLOCK_BIT(BLOCK_BIT), .BANK_BIT(BANK_BIT),
    .PRIV_BIT(PRIV_BIT), .RESET_VEC(RESET_VEC)
  ) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .take_i         (fault_valid_i),
    .mmu_i          (!use_raw_i),
    .status_i       (status_i),
    .pc_i           (pc_i),
    .r15_i          (r15_i),
    .addr_i         (fault_addr_i),
    .event_i        (evt),
    .target_i       (target),
    .status_o       (status_o),
    .saved_status_o (saved_status_o),
    .saved_pc_o     (saved_pc_o),
    .saved_r15_o    (saved_r15_o),
    .event_o        (event_o),
    .fault_addr_o   (fault_addr_o),
    .pc_o           (pc_o)
  );

  a_r7_multi_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid_i && !use_raw_i && fault_class_i == 3'd3) |=> pc_o == RESET_VEC);

  a_r6_miss_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid_i && !use_raw_i && (fault_class_i == 3'd0 || fault_class_i == 3'd2))
      |=> pc_o == $past(vbr_i) + MISS_OFS);
endmodule

// File: tb/tb_mmu_fault_entry.sv
module tb_mmu_fault_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_valid_i = 1'b0;
  logic        use_raw_i = 1'b0;
  logic [2:0]  fault_class_i = '0;
  logic [11:0] raw_code_i = '0;
  logic [31:0] fault_addr_i = '0, status_i = '0, pc_i = '0, vbr_i = '0, r15_i = '0;
  logic [31:0] status_o, saved_status_o, saved_pc_o, saved_r15_o, fault_addr_o, pc_o;
  logic [10:0] event_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmu_fault_entry dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] cls_code(input int c);
    case (c)
      0, 1: return 12'h040;
      2:    return 12'h060;
      3:    return 12'h140;
      4, 5: return 12'h0A0;
      6:    return 12'h0C0;
      default: return 12'h080;
    endcase
  endfunction

  function automatic logic [31:0] vec(input logic [11:0] code, input logic [31:0] vbr);
    if (code == 12'h140) return 32'hA000_0000;
    if (code == 12'h040 || code == 12'h060 || code == 12'h080) return vbr + 32'h400;
    return vbr + 32'h100;
  endfunction

  // Called at a negedge: applies one strobe cycle, returns at the next negedge
  task automatic fire(input bit raw, input int cls, input logic [11:0] rc,
                      input logic [31:0] a, input logic [31:0] s, input logic [31:0] p,
                      input logic [31:0] v, input logic [31:0] r);
    fault_valid_i = 1'b1; use_raw_i = raw; fault_class_i = cls[2:0]; raw_code_i = rc;
    fault_addr_i = a; status_i = s; pc_i = p; vbr_i = v; r15_i = r;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] vbrs [3];
    logic [31:0] last_addr;
    vbrs[0] = 32'h8C00_0000; vbrs[1] = 32'h0000_1000; vbrs[2] = 32'hFFFF_FC00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state (inputs idle through first cycle)
    chk("R1", "status",  status_o, 32'h7000_0000);
    chk("R1", "pc",      pc_o, 32'hA000_0000);
    chk("R1", "sstatus", saved_status_o, 0);
    chk("R1", "spc",     saved_pc_o, 0);
    chk("R1", "sr15",    saved_r15_o, 0);
    chk("R1", "event",   {21'd0, event_o}, 0);
    chk("R1", "addr",    fault_addr_o, 0);

    // R3 R4 R5 R6 R7 R8 R9 R10: class sweep, back to back
    for (int vi = 0; vi < 3; vi++) begin
      for (int c = 0; c < 8; c++) begin
        logic [31:0] s, a;
        s = 32'h0000_00F0 ^ (c << 4) ^ (vi << 28);
        a = 32'h4000_0000 + c * 32'h1234 + vi;
        fire(0, c, 12'hFFF, a, s, 32'h1000 + c, vbrs[vi], 32'h5500 + c);
        chk("R3", "status",  status_o, s | 32'h7000_0000);
        chk("R3", "sstatus", saved_status_o, s);
        chk("R3", "spc",     saved_pc_o, 32'h1000 + c);
        chk("R3", "sr15",    saved_r15_o, 32'h5500 + c);
        chk("R5", "event",   {21'd0, event_o}, {20'd0, cls_code(c) & 12'h7FF});
        chk("R6_R7_R8", "pc", pc_o, vec(cls_code(c), vbrs[vi]));
        chk("R9", "addr",    fault_addr_o, a);
        last_addr = a;
      end
    end

    // R2: idle cycle with changing inputs keeps everything
    begin
      logic [31:0] hs, hp, hv;
      hs = status_o; hp = pc_o; hv = saved_pc_o;
      fault_valid_i = 1'b0; status_i = 32'h1234_5678; pc_i = 32'h9; vbr_i = 32'h77;
      fault_addr_i = 32'hDEAD_BEEF; use_raw_i = 1'b0; fault_class_i = 3'd3;
      @(negedge clk);
      chk("R2", "status", status_o, hs);
      chk("R2", "pc",     pc_o, hp);
      chk("R2", "spc",    saved_pc_o, hv);
      chk("R2", "addr",   fault_addr_o, last_addr);
    end

    // R4 R6 R7 R8 R9 R10: every raw code back to back
    for (int rc = 0; rc < 4096; rc++) begin
      logic [31:0] v;
      v = vbrs[rc % 3];
      fire(1, 7, rc[11:0], 32'hCAFE_0000 + rc, rc, 32'h2000 + rc, v, 32'h0);
      chk("R4", "event", {21'd0, event_o}, {21'd0, rc[10:0]});
      chk("R8", "pc",    pc_o, vec(rc[11:0], v));
      chk("R9", "addr_raw", fault_addr_o, last_addr);
      chk("R10", "spc",  saved_pc_o, 32'h2000 + rc);
    end
    fault_valid_i = 1'b0;
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule